// File: doc/BRIEF.md
# Software-Driven Multi-Width SPI Shifter

This block gives a processor raw, record-by-record control over a serial memory bus. Software writes transmit records into a small queue. Each record carries 8 or 16 payload bits, a lane width (one, two or four data lines), a drive-enable bit for the wide modes and a flag that suppresses the matching receive entry. The engine shifts each record out in SPI mode 0: the clock idles low, outgoing bits change on falling clock edges, and incoming bits are sampled on rising edges. It collects the bits it receives into a receive queue, which software drains by popping as many records as it pushed.

Two chip-select lines can be held low by hand, independently of whether the engine is enabled. Each can also be asserted automatically for as long as the engine is busy. A single control word holds the enable, the chip-select controls and an 8-bit clock divisor. The status readback exposes the busy flag, the fill levels of both queues and their full and empty flags.

Top module: `spi_direct_engine`

## Requirements
- R1: After reset, SCK is low, both chip selects are high (deasserted), every data-lane output enable is 0, BUSY is 0, both queues report empty with level 0, and the control word reads back as 0.
- R2: Each SCK half-period lasts N system clock cycles, where N is the 8-bit divisor field (control bits [15:8]) and a field value of 0 means N = 256. The divisor is taken afresh at the start of every byte, so a change made during a record takes effect from the record's next byte onward.
- R3: Transfers follow SPI mode 0. The first bit of a record is on the data lines before the first rising SCK edge, later bits change only on falling edges, input is sampled on rising edges, and each byte travels most significant bit first.
- R4: A 16-bit record (record bit 18 set) sends its low byte first. Its receive entry is 16 bits, with the first byte received in bits [7:0]. An 8-bit record sends data bits [7:0] and returns its byte in receive bits [7:0], with bits [15:8] zero.
- R5: Record bits [17:16] select the lane width: 0 for one lane (output on SD0, input from SD1), 1 for two lanes (SD1:SD0), and 2 for four lanes (SD3:SD0). The higher-numbered lane carries the more significant bit. Code 3 behaves as one lane. A byte takes 8, 4 or 2 SCK pulses respectively, and widths may differ between records.
- R6: With one lane, SD0 is driven and SD1..SD3 are not, regardless of record bit 19. With two or four lanes, the lanes in use are driven when record bit 19 is 1, and no lane is driven when it is 0.
- R7: A record with bit 20 set produces no receive queue entry.
- R8: A record starts only when the engine is enabled (control bit 0), the transmit queue is non-empty and the receive queue has room. Consecutive records are chained with no idle cycle, so BUSY stays high across them. BUSY falls when the last record completes.
- R9: Control bits 1 and 2 drive chip selects 0 and 1 low, even when the engine is disabled. Control bits 3 and 4 assert chip selects 0 and 1 whenever BUSY is high.
- R10: A transmit write while the transmit queue is full is discarded. A receive read while the receive queue is empty leaves that queue unchanged.
- R11: The readback word holds the control fields at bits [4:0] and [15:8], BUSY at 16, TX full at 17, TX empty at 18, TX level at [21:19], RX empty at 22, RX full at 23 and RX level at [26:24]. Each queue holds 4 entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word: enable, manual and auto chip selects, divisor |
| csr_rdata | output | 32 | Control and status readback |
| tx_we | input | 1 | Push strobe for the transmit queue |
| tx_wdata | input | 21 | Transmit record: data, lane width, size, drive enable, no-push |
| rx_re | input | 1 | Pop strobe for the receive queue |
| rx_rdata | output | 16 | Head entry of the receive queue |
| sck | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip selects |
| sd_out | output | 4 | Data lane output values |
| sd_oe | output | 4 | Data lane output enables |
| sd_in | input | 4 | Data lane input values |

## Verification
The bench sweeps every lane-width code, both record sizes and both drive-enable values through a bus model that shifts data back on falling edges. In each case it compares the bits seen on rising edges, the lane enables and the received word against arithmetic expectations. A swapped byte order or a reversed lane order would show up as a scrambled word, and a drive-enable that ignored the single-lane rule would drive SD1 against the memory. Further checks measure rising-edge spacing to catch a divisor that is not re-read at a byte boundary or that decodes 0 as zero. They count busy cycles across chained records, which exposes an idle gap that would glitch an automatic chip select. Queue overflow and underflow are driven as well: a writer that did not discard on full would send a fifth record, and a receive side that did not stall on full would overwrite data.

// File: rtl/spi_direct_pkg.sv
package spi_direct_pkg;

    typedef enum logic [1:0] {
        LANE_X1  = 2'd0,
        LANE_X2  = 2'd1,
        LANE_X4  = 2'd2,
        LANE_RSV = 2'd3
    } lane_e;

    // Transmit record, most significant field first
    typedef struct packed {
        logic        nopush;
        logic        oe;
        logic        wide;
        lane_e       lanes;
        logic [15:0] data;
    } tx_rec_t;

    localparam int REC_W = $bits(tx_rec_t);

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_LOW  = 2'd1,
        SH_HIGH = 2'd2
    } sh_state_e;

    // log2 of the number of lanes in use; the reserved code folds to one lane
    function automatic logic [1:0] lane_log2(lane_e l);
        case (l)
            LANE_X2: return 2'd1;
            LANE_X4: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/spi_dir_fifo.sv
module spi_dir_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [LVL_W-1:0]            level;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.level != LVL_FULL);
        do_pop  = pop && (st_q.level != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr = (st_q.wr == PTR_LAST) ? '0 : st_q.wr + PTR_W'(1);
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == PTR_LAST) ? '0 : st_q.rd + PTR_W'(1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.level = st_q.level + LVL_W'(1);
            2'b01:   st_d.level = st_q.level - LVL_W'(1);
            default: st_d.level = st_q.level;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rd];
    assign level = st_q.level;
    assign full  = (st_q.level == LVL_FULL);
    assign empty = (st_q.level == '0);

    AST_FIFO_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_FULL); // R11
    AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full); // R10
    AST_FIFO_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R10

endmodule

// File: rtl/spi_dir_shifter.sv
module spi_dir_shifter
    import spi_direct_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [7:0]       div_code,
    input  logic             tx_empty,
    input  tx_rec_t          tx_rec,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [3:0]       sd_in,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [15:0]      rx_data,
    output logic             busy,
    output logic             sck,
    output logic [3:0]       sd_out,
    output logic [3:0]       sd_oe
);

    localparam logic [LVL_W-1:0] LVL_FULL   = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_ALMOST = LVL_W'(DEPTH - 1);

    typedef struct packed {
        sh_state_e   st;
        logic [7:0]  cnt;
        logic [7:0]  div_m1;
        logic [3:0]  beat;
        logic        second;
        lane_e       lanes;
        logic        wide;
        logic        oe;
        logic        nopush;
        logic [15:0] sh;
        logic [7:0]  rx_byte;
        logic [7:0]  rx_lo;
        logic        sck;
    } sh_st_t;

    sh_st_t st_d, st_q;

    function automatic logic [3:0] beats_m1(lane_e l);
        return (4'd8 >> lane_log2(l)) - 4'd1;
    endfunction

    function automatic sh_st_t load_rec(sh_st_t s, tx_rec_t r, logic [7:0] dcode);
        sh_st_t t;
        t         = s;
        t.st      = SH_LOW;
        t.cnt     = '0;
        t.div_m1  = dcode - 8'd1;
        t.beat    = beats_m1(r.lanes);
        t.second  = 1'b0;
        t.lanes   = r.lanes;
        t.wide    = r.wide;
        t.oe      = r.oe;
        t.nopush  = r.nopush;
        t.sh      = r.data;
        t.rx_byte = '0;
        t.rx_lo   = '0;
        t.sck     = 1'b0;
        return t;
    endfunction

    logic [3:0] amt;
    logic [7:0] sample;
    logic       start_ok;
    logic       chain_ok;

    always_comb begin
        amt = 4'd1 << lane_log2(st_q.lanes);
        case (lane_log2(st_q.lanes))
            2'd1:    sample = {6'b0, sd_in[1:0]};
            2'd2:    sample = {4'b0, sd_in};
            default: sample = {7'b0, sd_in[1]};
        endcase
        start_ok = enable && !tx_empty && (rx_level != LVL_FULL);
        chain_ok = enable && !tx_empty &&
                   (st_q.nopush ? (rx_level != LVL_FULL) : (rx_level < LVL_ALMOST));
    end

    always_comb begin
        st_d    = st_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_data = st_q.wide ? {st_q.rx_byte, st_q.rx_lo} : {8'h00, st_q.rx_byte};
        case (st_q.st)
            SH_IDLE: begin
                if (start_ok) begin
                    st_d   = load_rec(st_q, tx_rec, div_code);
                    tx_pop = 1'b1;
                end
            end
            SH_LOW: begin
                if (st_q.cnt == st_q.div_m1) begin
                    st_d.cnt     = '0;
                    st_d.st      = SH_HIGH;
                    st_d.sck     = 1'b1;
                    st_d.rx_byte = (st_q.rx_byte << amt) | sample;
                end else begin
                    st_d.cnt = st_q.cnt + 8'd1;
                end
            end
            SH_HIGH: begin
                if (st_q.cnt == st_q.div_m1) begin
                    st_d.cnt = '0;
                    st_d.sck = 1'b0;
                    if (st_q.beat != '0) begin
                        st_d.beat    = st_q.beat - 4'd1;
                        st_d.sh[7:0] = st_q.sh[7:0] << amt;
                        st_d.st      = SH_LOW;
                    end else if (st_q.wide && !st_q.second) begin
                        st_d.second  = 1'b1;
                        st_d.sh[7:0] = st_q.sh[15:8];
                        st_d.rx_lo   = st_q.rx_byte;
                        st_d.rx_byte = '0;
                        st_d.beat    = beats_m1(st_q.lanes);
                        st_d.div_m1  = div_code - 8'd1;
                        st_d.st      = SH_LOW;
                    end else begin
                        rx_push = !st_q.nopush;
                        if (chain_ok) begin
                            st_d   = load_rec(st_q, tx_rec, div_code);
                            tx_pop = 1'b1;
                        end else begin
                            st_d.st = SH_IDLE;
                        end
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 8'd1;
                end
            end
            default: st_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.st != SH_IDLE);
    assign sck  = st_q.sck;

    always_comb begin
        sd_out = 4'b0000;
        sd_oe  = 4'b0000;
        if (busy) begin
            case (lane_log2(st_q.lanes))
                2'd1: begin
                    sd_out = {2'b00, st_q.sh[7:6]};
                    sd_oe  = st_q.oe ? 4'b0011 : 4'b0000;
                end
                2'd2: begin
                    sd_out = st_q.sh[7:4];
                    sd_oe  = st_q.oe ? 4'b1111 : 4'b0000;
                end
                default: begin
                    sd_out = {3'b000, st_q.sh[7]};
                    sd_oe  = 4'b0001;
                end
            endcase
        end
    end

    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sck && sd_oe == 4'b0000)); // R3
    AST_SD1_NEVER_X1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lane_log2(st_q.lanes) == 2'd0) |-> !sd_oe[1]); // R6

endmodule

// File: rtl/spi_direct_engine.sv
module spi_direct_engine
    import spi_direct_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int RX_W       = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [15:0]       ctrl_wdata,
    output logic [31:0]       csr_rdata,
    input  logic              tx_we,
    input  logic [REC_W-1:0]  tx_wdata,
    input  logic              rx_re,
    output logic [RX_W-1:0]   rx_rdata,
    output logic              sck,
    output logic [1:0]        cs_n,
    output logic [3:0]        sd_out,
    output logic [3:0]        sd_oe,
    input  logic [3:0]        sd_in
);

    typedef struct packed {
        logic       en;
        logic [1:0] man;
        logic [1:0] autosel;
        logic [7:0] div;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  ctrl_unused;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) begin
            ctrl_d.en      = ctrl_wdata[0];
            ctrl_d.man     = ctrl_wdata[2:1];
            ctrl_d.autosel = ctrl_wdata[4:3];
            ctrl_d.div     = ctrl_wdata[15:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_unused = ^ctrl_wdata[7:5];

    logic [REC_W-1:0] tx_head;
    logic [LVL_W-1:0] tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_pop, rx_push, busy;
    logic [15:0]      rx_word;

    spi_dir_fifo #(.WIDTH(REC_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_we),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_head),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spi_dir_fifo #(.WIDTH(RX_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (RX_W'(rx_word)),
        .pop   (rx_re),
        .rdata (rx_rdata),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spi_dir_shifter #(.DEPTH(FIFO_DEPTH)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctrl_q.en),
        .div_code (ctrl_q.div),
        .tx_empty (tx_empty),
        .tx_rec   (tx_rec_t'(tx_head)),
        .rx_level (rx_level),
        .sd_in    (sd_in),
        .tx_pop   (tx_pop),
        .rx_push  (rx_push),
        .rx_data  (rx_word),
        .busy     (busy),
        .sck      (sck),
        .sd_out   (sd_out),
        .sd_oe    (sd_oe)
    );

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_cs
            assign cs_n[g] = !(ctrl_q.man[g] || (ctrl_q.autosel[g] && busy));
        end
    endgenerate

    always_comb begin
        csr_rdata        = '0;
        csr_rdata[0]     = ctrl_q.en;
        csr_rdata[2:1]   = ctrl_q.man;
        csr_rdata[4:3]   = ctrl_q.autosel;
        csr_rdata[15:8]  = ctrl_q.div;
        csr_rdata[16]    = busy;
        csr_rdata[17]    = tx_full;
        csr_rdata[18]    = tx_empty;
        csr_rdata[21:19] = 3'(tx_level);
        csr_rdata[22]    = rx_empty;
        csr_rdata[23]    = rx_full;
        csr_rdata[26:24] = 3'(rx_level);
    end

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.en && !busy) |=> !busy); // R8
    AST_RX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full); // R8
    AST_TX_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty); // R8

endmodule

// File: tb/spi_direct_engine_bench.sv
`timescale 1ns/1ps
module spi_direct_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [31:0] csr_rdata;
    logic        tx_we = 1'b0;
    logic [20:0] tx_wdata = '0;
    logic        rx_re = 1'b0;
    logic [15:0] rx_rdata;
    logic        sck;
    logic [1:0]  cs_n;
    logic [3:0]  sd_out, sd_oe;
    logic [3:0]  sd_in;

    int n_checks = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    spi_direct_engine u_spi_direct_engine (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .csr_rdata(csr_rdata), .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re),
        .rx_rdata(rx_rdata), .sck(sck), .cs_n(cs_n), .sd_out(sd_out), .sd_oe(sd_oe),
        .sd_in(sd_in)
    );

    // bus model state
    int          amt = 1;
    logic [15:0] slave_sh = '0;
    logic [15:0] cap = '0;
    logic [3:0]  exp_oe = 4'b0001;
    int          oe_err = 0;
    int          cs_err = 0;
    bit          cs_watch = 0;
    int          rise_n = 0;
    time         rise_t [0:63];

    always_comb begin
        case (amt)
            2:       sd_in = {2'b00, slave_sh[15:14]};
            4:       sd_in = slave_sh[15:12];
            default: sd_in = {2'b00, slave_sh[15], 1'b0};
        endcase
    end

    always @(posedge sck) begin
        logic [3:0] bits;
        case (amt)
            2:       bits = {2'b00, sd_out[1:0]};
            4:       bits = sd_out;
            default: bits = {3'b000, sd_out[0]};
        endcase
        cap = (cap << amt) | 16'(bits);
        if (sd_oe !== exp_oe) oe_err++;
        if (cs_watch && cs_n[0] !== 1'b0) cs_err++;
        rise_t[rise_n % 64] = $time;
        rise_n++;
    end

    always @(negedge sck) slave_sh = slave_sh << amt;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [15:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic push(input logic [20:0] r);
        @(negedge clk); tx_we = 1'b1; tx_wdata = r;
        @(negedge clk); tx_we = 1'b0;
    endtask

    task automatic pop(output logic [15:0] v);
        @(negedge clk); v = rx_rdata; rx_re = 1'b1;
        @(negedge clk); rx_re = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (csr_rdata[16]) @(negedge clk);
    endtask

    function automatic logic [20:0] mkrec(input bit nopush, input bit oe, input bit wide,
                                          input logic [1:0] w, input logic [15:0] d);
        return {nopush, oe, wide, w, d};
    endfunction

    initial begin
        #(5.0 * 190000);
        n_err++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 sck", 32'(sck), 0);
        chk("R1 cs_n", 32'(cs_n), 32'h3);
        chk("R1 sd_oe", 32'(sd_oe), 0);
        chk("R1 readback", csr_rdata, 32'h0044_0000);

        // Sweep: lane width x size x drive enable
        for (int w = 0; w < 4; w++) begin
            for (int big = 0; big < 2; big++) begin
                for (int oe = 0; oe < 2; oe++) begin
                    int          div = ((w + big + oe) % 3) + 1;
                    logic [15:0] pat = 16'h5A3C + 16'(w) * 16'h1111 + 16'(big) * 16'h0707 + 16'(oe) * 16'h2222;
                    logic [15:0] txd = ~pat ^ 16'(w * 37);
                    logic [15:0] exp_cap;
                    logic [15:0] exp_rx;
                    int          beats;
                    write_ctrl({8'(div), 8'b0000_1001});
                    amt    = (w == 1) ? 2 : (w == 2) ? 4 : 1;
                    exp_oe = (amt == 1) ? 4'b0001 : (oe == 0) ? 4'b0000 : (amt == 2) ? 4'b0011 : 4'b1111;
                    slave_sh = big ? {pat[7:0], pat[15:8]} : {pat[7:0], 8'h00};
                    cap = '0; rise_n = 0; oe_err = 0; cs_err = 0; cs_watch = 1;
                    push(mkrec(1'b0, oe[0], big[0], w[1:0], txd));
                    wait_idle();
                    cs_watch = 0;
                    beats   = (big ? 16 : 8) / amt;
                    exp_cap = big ? {txd[7:0], txd[15:8]} : {8'h00, txd[7:0]};
                    exp_rx  = big ? pat : {8'h00, pat[7:0]};
                    chk("R5 pulse count", rise_n, beats);
                    if (oe || amt == 1) chk("R3 R4 R5 sent bits", 32'(cap), 32'(exp_cap));
                    chk("R6 lane enables", oe_err, 0);
                    chk("R2 period", 32'(rise_t[1] - rise_t[0]), 32'(2 * div * 5));
                    chk("R9 auto cs during busy", cs_err, 0);
                    chk("R9 auto cs released", 32'(cs_n), 32'h3);
                    chk("R11 rx level", 32'(csr_rdata[26:24]), 1);
                    pop(v);
                    chk("R4 R5 received word", 32'(v), 32'(exp_rx));
                end
            end
        end

        // R7 no-push record
        write_ctrl(16'h0101);
        amt = 1; exp_oe = 4'b0001; slave_sh = 16'hC300;
        push(mkrec(1'b1, 1'b0, 1'b0, 2'd0, 16'h0011));
        wait_idle();
        chk("R7 no entry", 32'(csr_rdata[26:24]), 0);
        slave_sh = 16'h9600;
        push(mkrec(1'b0, 1'b0, 1'b0, 2'd0, 16'h0022));
        wait_idle();
        pop(v);
        chk("R7 normal entry after", 32'(v), 32'h96);

        // R2 divisor re-read at byte boundary
        write_ctrl(16'h0201);
        rise_n = 0; slave_sh = 16'h1234;
        push(mkrec(1'b0, 1'b0, 1'b1, 2'd0, 16'hBEEF));
        while (rise_n < 2) @(negedge clk);
        write_ctrl(16'h0501);
        wait_idle();
        chk("R2 first byte period", 32'(rise_t[1] - rise_t[0]), 20);
        chk("R2 second byte period", 32'(rise_t[15] - rise_t[14]), 50);
        pop(v);

        // R2 divisor code 0 means 256
        write_ctrl(16'h0001);
        amt = 4; exp_oe = 4'b1111; rise_n = 0;
        push(mkrec(1'b1, 1'b1, 1'b0, 2'd2, 16'h00A5));
        wait_idle();
        chk("R2 divisor 256", 32'(rise_t[1] - rise_t[0]), 2560);

        // R8 chained records keep busy high
        amt = 1; exp_oe = 4'b0001;
        write_ctrl(16'h0100);
        for (int i = 0; i < 3; i++) push(mkrec(1'b1, 1'b0, 1'b0, 2'd0, 16'(i)));
        repeat (4) @(negedge clk);
        chk("R8 disabled no start", 32'(csr_rdata[16]), 0);
        chk("R11 tx level", 32'(csr_rdata[21:19]), 3);
        begin
            int  rises = 0, hi = 0;
            bit  prev = 0;
            write_ctrl(16'h0109);
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (csr_rdata[16] && !prev) rises++;
                if (csr_rdata[16]) hi++;
                prev = csr_rdata[16];
            end
            chk("R8 single busy episode", rises, 1);
            chk("R8 R2 busy cycles", hi, 48);
        end

        // R10 R11 overflow and underflow
        write_ctrl(16'h0100);
        rise_n = 0;
        for (int i = 0; i < 5; i++) push(mkrec(1'b0, 1'b0, 1'b0, 2'd0, 16'(i + 1)));
        chk("R11 tx full level", 32'(csr_rdata[21:19]), 4);
        chk("R11 tx full flag", 32'(csr_rdata[18:17]), 32'h1);
        write_ctrl(16'h0101);
        wait_idle();
        chk("R10 extra write discarded", rise_n, 32);
        chk("R11 rx full", 32'({csr_rdata[26:22]}), 32'b10010);
        push(mkrec(1'b0, 1'b0, 1'b0, 2'd0, 16'h0077));
        repeat (20) @(negedge clk);
        chk("R8 stall on rx full busy", 32'(csr_rdata[16]), 0);
        chk("R8 stall on rx full tx level", 32'(csr_rdata[21:19]), 1);
        pop(v);
        wait_idle();
        chk("R8 resumes after pop", 32'(csr_rdata[26:24]), 4);
        for (int i = 0; i < 4; i++) pop(v);
        pop(v);
        chk("R10 empty read level", 32'(csr_rdata[26:24]), 0);
        chk("R10 empty flag", 32'(csr_rdata[22]), 1);

        // R9 manual chip selects with engine disabled
        write_ctrl(16'h0004);
        @(negedge clk);
        chk("R9 manual cs1", 32'(cs_n), 32'h1);
        write_ctrl(16'h0002);
        @(negedge clk);
        chk("R9 manual cs0", 32'(cs_n), 32'h2);
        write_ctrl(16'h0018);
        @(negedge clk);
        chk("R9 auto idle", 32'(cs_n), 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule